// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block arbitrates seven interrupt sources for a small controller core. The sources are two external lines, three timer overflows, an analog-to-digital conversion-done event and a serial transfer event (done or aborted). Each source has a pending flag and a mask bit. One global enable covers all of them. A source whose pending flag is 1 and whose mask is 0 raises a request. When the global enable is 1 and no acknowledge is in progress, the controller picks the winner by fixed priority and runs a three-cycle acknowledge. The acknowledge signals that the current instruction finishes, strobes two push slots for the return context, drops the global enable and issues a jump to the winner's vector.

Software reaches the flags, masks and global enable through a bit-operation port. The port takes a bit-set, a bit-clear or a bit-test, and the chosen bit is selected by a 4-bit index. Pending flags can only be raised by hardware events, and software can only clear them. The block carries no data stream, so every pin is a plain control or status signal with no valid/ready handshake. Edge detection of the external lines, the stack memory and the instruction decoder sit outside this block.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A source requests when its pending flag is 1 and its mask is 0. While the global enable is 0, no acknowledge starts, however many requests are pending.
- R2: Reset (synchronous, active high) clears all pending flags and the global enable to 0 and sets all masks to 1. After reset, take_int, push_en, jump_en and status_bit are 0.
- R3: The bit_op encoding is 0 = none, 1 = set, 2 = clear and 3 = test. The bit_sel map is: 0..6 are the pending flags of sources 0..6, 7 is the global enable, 8..14 are the masks of sources 0..6, and 15 reads 0 and ignores writes. Set and clear take effect at the next clock edge.
- R4: A set operation aimed at a pending flag (bit_sel 0..6) leaves that flag unchanged.
- R5: Source order on hw_evt is: bit 0 external 0, bit 1 external 1, bit 2 timer A, bit 3 timer B, bit 4 timer C, bit 5 A/D done, bit 6 serial. Source i has vector 2*(i+1), which gives 0x0002 through 0x000E. When several sources request at once, the lowest index wins.
- R6: An acknowledge starts at the clock edge after a request is seen with the global enable at 1. The three cycles are:
  - Cycle 1: take_int = 1.
  - Cycle 2: push_en = 1 with push_slot = 0.
  - Cycle 3: push_en = 1 with push_slot = 1, jump_en = 1, and vector holds the winner's address.
  The global enable is cleared at the end of cycle 2. When this clear and a software set of the enable meet in the same cycle, the clear wins.
- R7: A pending flag stays 1 after its acknowledge until software clears it. When a hardware event and a software clear of the same flag arrive in the same cycle, the flag ends up set.
- R8: A test operation loads the selected bit into status_bit at the next clock edge. status_bit then holds that value until the next test.
- R9: No second acknowledge starts while one is in progress, or afterwards while the global enable stays 0, even if flags remain pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_evt | input | 7 | One-cycle hardware event per source; sets the pending flag |
| bit_op | input | 2 | Bit operation: 0 none, 1 set, 2 clear, 3 test |
| bit_sel | input | 4 | Bit index for bit_op |
| status_bit | output | 1 | Result of the last test operation |
| take_int | output | 1 | Acknowledge cycle 1: current instruction completes |
| push_en | output | 1 | Context push strobe, cycles 2 and 3 |
| push_slot | output | 1 | Push slot: 0 in cycle 2, 1 in cycle 3 |
| jump_en | output | 1 | Acknowledge cycle 3: load vector into program counter |
| vector | output | 14 | Vector address of the acknowledged source |

## Verification
Each source is raised alone and acknowledged. Because every source produces a different vector, this catches a wrong index-to-vector mapping. A mixed set of simultaneous requests is then resolved one winner at a time, clearing each winner in turn; this tells a priority order apart from a mapping that only works for single sources. The acknowledge is checked cycle by cycle against take_int, push_en/push_slot, jump_en and the enable readback, which exposes an off-by-one cycle in the sequence. Finally, colliding software-clear and hardware-event pulses, software sets on flags, and requests with the enable off separate correct gating from logic that is merely plausible.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_TEST  = 2'd3
  } bit_op_e;

  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_C1   = 2'd1,
    ACK_C2   = 2'd2,
    ACK_C3   = 2'd3
  } ack_state_e;
endpackage

// File: rtl/irqc_bit_bank.sv
module irqc_bit_bank
  import irqc_pkg::*;
#(
  parameter int NSRC  = 7,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  hw_evt,
  input  logic [1:0]       bit_op,
  input  logic [SEL_W-1:0] bit_sel,
  input  logic             ack_clr_gie,
  output logic [NSRC-1:0]  flag_q,
  output logic [NSRC-1:0]  mask_q,
  output logic             gie_q,
  output logic             status_q
);
  localparam int IDX_W = SEL_W - 1;

  bit_op_e            op;
  logic               region_mask;
  logic [IDX_W-1:0]   idx;
  logic               rd_bit;

  assign op          = bit_op_e'(bit_op);
  assign region_mask = bit_sel[SEL_W-1];
  assign idx         = bit_sel[IDX_W-1:0];

  always_comb begin
    rd_bit = 1'b0;
    if (!region_mask && int'(idx) < NSRC)       rd_bit = flag_q[idx];
    else if (!region_mask && int'(idx) == NSRC) rd_bit = gie_q;
    else if (region_mask && int'(idx) < NSRC)   rd_bit = mask_q[idx];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic hit_flag, hit_mask;
    assign hit_flag = !region_mask && (int'(idx) == i);
    assign hit_mask = region_mask && (int'(idx) == i);

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
        mask_q[i] <= 1'b1;
      end else begin
        if (hw_evt[i])                             flag_q[i] <= 1'b1;
        else if (hit_flag && op == OP_CLEAR)       flag_q[i] <= 1'b0;
        if (hit_mask && op == OP_SET)              mask_q[i] <= 1'b1;
        else if (hit_mask && op == OP_CLEAR)       mask_q[i] <= 1'b0;
      end
    end

    a_r4_hw_only_sets_flag: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_q[i]) |-> $past(hw_evt[i]));
    a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
      hw_evt[i] |=> flag_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q    <= 1'b0;
      status_q <= 1'b0;
    end else begin
      if (ack_clr_gie)
        gie_q <= 1'b0;
      else if (!region_mask && int'(idx) == NSRC && op == OP_SET)
        gie_q <= 1'b1;
      else if (!region_mask && int'(idx) == NSRC && op == OP_CLEAR)
        gie_q <= 1'b0;
      if (op == OP_TEST) status_q <= rd_bit;
    end
  end

  a_r6_ack_clears_gie: assert property (@(posedge clk) disable iff (rst)
    ack_clr_gie |=> !gie_q);
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int NSRC   = 7,
  parameter int VEC_W  = 14,
  parameter int STRIDE = 2
) (
  input  logic [NSRC-1:0]  req,
  output logic             any_req,
  output logic [VEC_W-1:0] vec
);
  localparam int GW = $clog2(NSRC);

  logic [GW-1:0] grant;

  always_comb begin
    grant = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) grant = GW'(i);
    end
  end

  assign any_req = |req;
  assign vec     = VEC_W'(STRIDE) * (VEC_W'(grant) + VEC_W'(1));
endmodule

// File: rtl/irqc_ack_seq.sv
module irqc_ack_seq
  import irqc_pkg::*;
#(
  parameter int VEC_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_req,
  input  logic             gie,
  input  logic [VEC_W-1:0] vec_in,
  output logic             take_int,
  output logic             push_en,
  output logic             push_slot,
  output logic             jump_en,
  output logic             clr_gie,
  output logic [VEC_W-1:0] vector
);
  ack_state_e state_q;
  logic       start;

  assign start = (state_q == ACK_IDLE) && gie && any_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ACK_IDLE;
      vector  <= '0;
    end else begin
      case (state_q)
        ACK_IDLE: if (start) begin
          state_q <= ACK_C1;
          vector  <= vec_in;
        end
        ACK_C1:   state_q <= ACK_C2;
        ACK_C2:   state_q <= ACK_C3;
        default:  state_q <= ACK_IDLE;
      endcase
    end
  end

  assign take_int  = (state_q == ACK_C1);
  assign push_en   = (state_q == ACK_C2) || (state_q == ACK_C3);
  assign push_slot = (state_q == ACK_C3);
  assign jump_en   = (state_q == ACK_C3);
  assign clr_gie   = (state_q == ACK_C2);

  a_r1_take_needs_gie: assert property (@(posedge clk) disable iff (rst)
    take_int |-> $past(gie) && $past(any_req));
  a_r6_take_then_push: assert property (@(posedge clk) disable iff (rst)
    take_int |=> push_en && !push_slot && !jump_en);
  a_r6_jump_in_slot1: assert property (@(posedge clk) disable iff (rst)
    jump_en |-> push_en && push_slot && !gie);
  a_r5_vector_even: assert property (@(posedge clk) disable iff (rst)
    jump_en |-> (vector[0] == 1'b0) && (vector != '0));
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    jump_en |=> !take_int);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC   = 7,
  parameter int VEC_W  = 14,
  parameter int STRIDE = 2,
  parameter int SEL_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  hw_evt,
  input  logic [1:0]       bit_op,
  input  logic [SEL_W-1:0] bit_sel,
  output logic             status_bit,
  output logic             take_int,
  output logic             push_en,
  output logic             push_slot,
  output logic             jump_en,
  output logic [VEC_W-1:0] vector
);
  logic [NSRC-1:0]  flag_q, mask_q, req;
  logic             gie_q, clr_gie, any_req;
  logic [VEC_W-1:0] vec_sel;

  irqc_bit_bank #(.NSRC(NSRC), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst(rst), .hw_evt(hw_evt), .bit_op(bit_op), .bit_sel(bit_sel),
    .ack_clr_gie(clr_gie), .flag_q(flag_q), .mask_q(mask_q), .gie_q(gie_q),
    .status_q(status_bit)
  );

  assign req = flag_q & ~mask_q;

  irqc_prio #(.NSRC(NSRC), .VEC_W(VEC_W), .STRIDE(STRIDE)) u_prio (
    .req(req), .any_req(any_req), .vec(vec_sel)
  );

  irqc_ack_seq #(.VEC_W(VEC_W)) u_seq (
    .clk(clk), .rst(rst), .any_req(any_req), .gie(gie_q), .vec_in(vec_sel),
    .take_int(take_int), .push_en(push_en), .push_slot(push_slot),
    .jump_en(jump_en), .clr_gie(clr_gie), .vector(vector)
  );

  a_r2_masked_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (req == '0) && !take_int);
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  hw_evt = '0;
  logic [1:0]  bit_op = 2'd0;
  logic [3:0]  bit_sel = '0;
  logic        status_bit, take_int, push_en, push_slot, jump_en;
  logic [13:0] vector;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst(rst), .hw_evt(hw_evt), .bit_op(bit_op), .bit_sel(bit_sel),
    .status_bit(status_bit), .take_int(take_int), .push_en(push_en),
    .push_slot(push_slot), .jump_en(jump_en), .vector(vector)
  );

  task automatic step(); @(negedge clk); endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [3:0] sel);
    bit_op = op; bit_sel = sel; step(); bit_op = 2'd0;
  endtask

  task automatic read_bit(input logic [3:0] sel, input string req, input int exp);
    do_op(2'd3, sel); chk(req, status_bit, exp);
  endtask

  task automatic pulse(input logic [6:0] ev);
    hw_evt = ev; step(); hw_evt = '0;
  endtask

  // drives the enable set; then expects the full three-cycle acknowledge
  task automatic run_ack(input int exp_vec, input string req);
    do_op(2'd1, 4'd7);
    step(); chk({req, " R6 c1 take"}, take_int, 1); chk({req, " R6 c1 push"}, push_en, 0);
    step(); chk({req, " R6 c2 push"}, push_en, 1); chk({req, " R6 c2 slot"}, push_slot, 0);
    chk({req, " R6 c2 jump"}, jump_en, 0);
    step(); chk({req, " R6 c3 slot"}, push_slot, 1); chk({req, " R6 c3 jump"}, jump_en, 1);
    chk({req, " R5 vector"}, vector, exp_vec);
    step(); chk({req, " R9 idle"}, take_int | push_en | jump_en, 0);
  endtask

  task automatic t_reset();
    repeat (3) step();
    rst = 1'b0; step();
    chk("R2 take", take_int, 0); chk("R2 push", push_en, 0);
    chk("R2 jump", jump_en, 0); chk("R2 status", status_bit, 0);
    read_bit(4'd0, "R2 flag0", 0); read_bit(4'd7, "R2 gie", 0);
    read_bit(4'd8, "R2 mask0", 1); read_bit(4'd14, "R2 mask6", 1);
  endtask

  task automatic t_bit_ops();
    do_op(2'd2, 4'd10); read_bit(4'd10, "R3 mask2 clear", 0);
    read_bit(4'd9, "R3 mask1 untouched", 1);
    do_op(2'd1, 4'd10); read_bit(4'd10, "R3 mask2 set", 1);
    do_op(2'd1, 4'd15); read_bit(4'd15, "R3 sel15 reads 0", 0);
    do_op(2'd1, 4'd7); read_bit(4'd7, "R8 gie set", 1);
    read_bit(4'd8, "R8 status follows test", 1);
    do_op(2'd2, 4'd7); read_bit(4'd7, "R3 gie clear", 0);
  endtask

  task automatic t_sw_cannot_set();
    for (int i = 0; i < 7; i++) begin
      do_op(2'd1, 4'(i));
      read_bit(4'(i), "R4 sw set ignored", 0);
    end
  endtask

  task automatic t_gie_gate();
    do_op(2'd2, 4'd8); pulse(7'h01);
    repeat (4) begin step(); chk("R1 no take gie=0", take_int, 0); end
    run_ack(2, "R1 single src0");
    read_bit(4'd7, "R6 gie cleared", 0);
    read_bit(4'd0, "R7 flag kept", 1);
    repeat (3) begin step(); chk("R9 no retrigger", take_int, 0); end
    do_op(2'd2, 4'd0); read_bit(4'd0, "R7 sw clear", 0);
    do_op(2'd1, 4'd8);
  endtask

  task automatic t_each_source();
    for (int i = 0; i < 7; i++) begin
      do_op(2'd2, 4'(8 + i)); pulse(7'(1 << i));
      run_ack(2 * (i + 1), "R5 each");
      do_op(2'd2, 4'(i)); do_op(2'd1, 4'(8 + i));
    end
  endtask

  task automatic t_priority();
    for (int i = 0; i < 7; i++) do_op(2'd2, 4'(8 + i));
    pulse(7'b1101100);
    run_ack(6, "R5 prio timerA");
    do_op(2'd2, 4'd2); run_ack(8, "R5 prio timerB");
    do_op(2'd2, 4'd3); run_ack(12, "R5 prio adc");
    do_op(2'd2, 4'd5); run_ack(14, "R5 prio serial");
    do_op(2'd2, 4'd6);
    do_op(2'd1, 4'd10); pulse(7'b0000110);
    run_ack(4, "R1 masked src2 skipped");
    do_op(2'd2, 4'd1); do_op(2'd2, 4'd2);
    for (int i = 0; i < 7; i++) do_op(2'd1, 4'(8 + i));
  endtask

  task automatic t_race();
    hw_evt = 7'h10; bit_op = 2'd2; bit_sel = 4'd4; step();
    hw_evt = '0; bit_op = 2'd0;
    read_bit(4'd4, "R7 event beats clear", 1);
    do_op(2'd2, 4'd4); read_bit(4'd4, "R7 clear alone", 0);
  endtask

  initial begin
    t_reset();
    t_bit_ops();
    t_sw_cannot_set();
    t_gie_gate();
    t_each_source();
    t_priority();
    t_race();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule